// File: doc/BRIEF.md
# Multiplex-by-four LCD drive sequencer

This block produces the drive timing for a liquid-crystal panel that time-shares four common electrodes (backplanes) across a set of segment electrodes (frontplanes). It counts a slow oscillator clock into four equal time slots per frame. In each slot it selects one backplane. For every output it emits a 2-bit code that tells the analog level generator which of four bias voltages to apply. Each frontplane code depends on the image bit that belongs to that frontplane and the backplane currently selected.

Drive polarity is inverted on every other frame, so each segment sees zero net DC over a pair of frames. The segment image is copied into an internal frame buffer only at a frame boundary (and while reset is held), so a frame never shows half of an old image and half of a new one. Each output also carries a high-current flag. The flag is raised on the cycle that output's code changes and held for a fixed number of oscillator cycles, so the output buffer can charge the panel capacitance quickly before dropping back to low current.

Top module: `lcdmux_drive`

## Requirements
- R1: On the first cycle after a synchronous reset, backplane 0 carries code 3 and backplanes 1 to 3 carry code 1. When reset was held for at least two cycles, every high-current flag is low on that cycle.
- R2: Backplanes are selected in the order 0, 1, 2, 3, 0, and so on. Each selection lasts exactly SLOT_DIV clock cycles, so a frame lasts 4*SLOT_DIV cycles.
- R3: In a positive frame the selected backplane carries code 3 and the other three carry code 1. In a negative frame the selected backplane carries code 0 and the others carry code 2.
- R4: Frontplane f with backplane b selected uses image bit 4*f+b, where 1 means the segment is lit. In a positive frame a lit segment gives code 0 and a dark one gives code 2. In a negative frame a lit segment gives code 3 and a dark one gives code 1.
- R5: The first frame after reset is positive, and polarity inverts at every frame boundary.
- R6: The image input is captured on the clock edge that ends slot 3 and on every edge while reset is high. A change to the image at any other time has no effect on the frontplane codes until the next frame begins.
- R7: An output's high-current flag is high on the first cycle that output's code differs from the previous cycle, and for the following BOOST_CYC-1 cycles. Otherwise it is low. A new change inside a window restarts the window.
- R8: Over any even/odd frame pair that shows the same image, the sum of (backplane code minus frontplane code) across all cycles is zero for every backplane/frontplane pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_image | input | 4*NUM_FP | Segment image, bit 4*f+b is frontplane f on backplane b |
| bp_level | output | 8 | Backplane drive codes, backplane b at bits 2*b+1:2*b |
| bp_boost | output | 4 | High-current flag per backplane |
| fp_level | output | 2*NUM_FP | Frontplane drive codes, frontplane f at bits 2*f+1:2*f |
| fp_boost | output | NUM_FP | High-current flag per frontplane |

## Verification
The bench runs a small configuration whose slots are shorter than the boost window, so windows overlap and restart. It compares every output on every cycle against an arithmetic model across 24 image pairs:
- Blank and fully lit images show pure backplane transitions with no frontplane activity.
- Alternating-bit images make each frontplane toggle at every slot.
- A single walking one isolates each image bit index in turn.
- Scrambled values mix the above cases.

Brief inversions of the image inside a frame show whether capture happens anywhere other than the frame edge. The per-segment DC sum over each frame pair exposes any polarity or level-mapping error that a single frame would hide.

// File: rtl/lcdmux_pkg.sv
package lcdmux_pkg;

    localparam int BP_COUNT = 4;
    localparam int LVL_W    = 2;

    typedef enum logic [1:0] {
        LVL_GND  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_TOP  = 2'd3
    } drive_lvl_e;

    typedef struct packed {
        logic [1:0] slot;
        logic       neg;
    } phase_t;

    // Backplane: extreme level when selected, middle level otherwise.
    function automatic drive_lvl_e bp_drive(input logic sel, input logic neg);
        drive_lvl_e r;
        if (neg) r = sel ? LVL_GND : LVL_HIGH;
        else     r = sel ? LVL_TOP : LVL_LOW;
        return r;
    endfunction

    // Frontplane: opposite extreme for a lit segment, far middle for a dark one.
    function automatic drive_lvl_e fp_drive(input logic lit, input logic neg);
        drive_lvl_e r;
        if (neg) r = lit ? LVL_TOP : LVL_LOW;
        else     r = lit ? LVL_GND : LVL_HIGH;
        return r;
    endfunction

endpackage

// File: rtl/lcdmux_timebase.sv
module lcdmux_timebase
    import lcdmux_pkg::*;
#(
    parameter int SLOT_DIV = 250
) (
    input  logic   clk,
    input  logic   rst,
    output phase_t phase,
    output logic   frame_load
);

    localparam int DIV_W = (SLOT_DIV > 1) ? $clog2(SLOT_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOT_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic             slot_end;

    assign slot_end   = (div_q == DIV_LAST);
    assign frame_load = slot_end && (phase.slot == 2'(BP_COUNT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            phase <= '0;
        end else begin
            if (slot_end) begin
                div_q      <= '0;
                phase.slot <= phase.slot + 2'd1;
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
            if (frame_load) phase.neg <= ~phase.neg;
        end
    end

endmodule

// File: rtl/lcdmux_frame_latch.sv
module lcdmux_frame_latch #(
    parameter int WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || load) q <= d;
    end

endmodule

// File: rtl/lcdmux_boost.sv
module lcdmux_boost
    import lcdmux_pkg::*;
#(
    parameter int N         = 4,
    parameter int BOOST_CYC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N*LVL_W-1:0] lvl,
    output logic [N-1:0]       boost
);

    localparam int CW = (BOOST_CYC > 2) ? $clog2(BOOST_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(BOOST_CYC - 1);

    for (genvar i = 0; i < N; i++) begin : g_out
        logic [LVL_W-1:0] prev_q;
        logic [CW-1:0]    rem_q;
        logic             moved;

        assign moved    = (lvl[i*LVL_W +: LVL_W] != prev_q);
        assign boost[i] = moved || (rem_q != '0);

        always_ff @(posedge clk) begin
            prev_q <= lvl[i*LVL_W +: LVL_W];
            if (rst)                rem_q <= '0;
            else if (moved)         rem_q <= RELOAD;
            else if (rem_q != '0)   rem_q <= rem_q - CW'(1);
        end
    end

endmodule

// File: rtl/lcdmux_drive.sv
module lcdmux_drive
    import lcdmux_pkg::*;
#(
    parameter int NUM_FP    = 32,
    parameter int SLOT_DIV  = 250,
    parameter int BOOST_CYC = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [4*NUM_FP-1:0]      seg_image,
    output logic [2*4-1:0]           bp_level,
    output logic [3:0]               bp_boost,
    output logic [2*NUM_FP-1:0]      fp_level,
    output logic [NUM_FP-1:0]        fp_boost
);

    localparam int NUM_SEG = BP_COUNT * NUM_FP;

    phase_t             phase;
    logic               frame_load;
    logic [NUM_SEG-1:0] frame_img;

    lcdmux_timebase #(.SLOT_DIV(SLOT_DIV)) u_tb (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .frame_load (frame_load)
    );

    lcdmux_frame_latch #(.WIDTH(NUM_SEG)) u_img (
        .clk  (clk),
        .rst  (rst),
        .load (frame_load),
        .d    (seg_image),
        .q    (frame_img)
    );

    for (genvar b = 0; b < BP_COUNT; b++) begin : g_bp
        assign bp_level[b*LVL_W +: LVL_W] = bp_drive(phase.slot == 2'(b), phase.neg);
    end

    for (genvar f = 0; f < NUM_FP; f++) begin : g_fp
        logic [BP_COUNT-1:0] column;
        assign column = frame_img[f*BP_COUNT +: BP_COUNT];
        assign fp_level[f*LVL_W +: LVL_W] = fp_drive(column[phase.slot], phase.neg);
    end

    lcdmux_boost #(.N(BP_COUNT), .BOOST_CYC(BOOST_CYC)) u_bp_boost (
        .clk   (clk),
        .rst   (rst),
        .lvl   (bp_level),
        .boost (bp_boost)
    );

    lcdmux_boost #(.N(NUM_FP), .BOOST_CYC(BOOST_CYC)) u_fp_boost (
        .clk   (clk),
        .rst   (rst),
        .lvl   (fp_level),
        .boost (fp_boost)
    );

endmodule

// File: rtl/lcdmux_drive_chk.sv
module lcdmux_drive_chk #(
    parameter int NUM_FP    = 32,
    parameter int SLOT_DIV  = 250,
    parameter int BOOST_CYC = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [7:0]          bp_level,
    input logic [3:0]          bp_boost,
    input logic [2*NUM_FP-1:0] fp_level,
    input logic [NUM_FP-1:0]   fp_boost
);

    localparam int LEN_W = $clog2(SLOT_DIV + 2) + 1;
    localparam int AGE_W = $clog2(BOOST_CYC + 1) + 1;
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(SLOT_DIV + 1);
    localparam logic [AGE_W-1:0] AGE_CAP = AGE_W'(BOOST_CYC);

    logic [3:0]       ext;
    logic [1:0]       sel, sel_q;
    logic             neg, neg_q;
    logic [LEN_W-1:0] len_q;

    always_comb begin
        sel = '0;
        for (int i = 0; i < 4; i++) begin
            ext[i] = (bp_level[2*i +: 2] == 2'd0) || (bp_level[2*i +: 2] == 2'd3);
            if (ext[i]) sel = 2'(i);
        end
    end

    assign neg = ~bp_level[0];

    always_ff @(posedge clk) begin
        sel_q <= sel;
        neg_q <= neg;
        if (rst)                 len_q <= '0;
        else if (sel != sel_q)   len_q <= LEN_W'(1);
        else if (len_q != LEN_CAP) len_q <= len_q + LEN_W'(1);
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> bp_level == 8'h57); // R1
    AST_SLOT_LEN: assert property (@(posedge clk) disable iff (rst)
        (sel != sel_q && len_q != '0) |-> len_q == LEN_W'(SLOT_DIV)); // R2
    AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (rst)
        (sel != sel_q && len_q != '0) |-> sel == sel_q + 2'd1); // R2
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $countones(ext) == 1); // R3
    AST_BP_PARITY: assert property (@(posedge clk) disable iff (rst)
        (bp_level[2] == bp_level[0]) && (bp_level[4] == bp_level[0]) && (bp_level[6] == bp_level[0])); // R3
    AST_POL_WRAP: assert property (@(posedge clk) disable iff (rst)
        (sel != sel_q && len_q != '0 && sel == 2'd0) |-> neg != neg_q); // R5
    AST_POL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (len_q != '0 && (sel == sel_q || sel != 2'd0)) |-> neg == neg_q); // R5

    for (genvar f = 0; f < NUM_FP; f++) begin : g_fp_chk
        AST_FP_PARITY: assert property (@(posedge clk) disable iff (rst)
            fp_level[2*f] != bp_level[0]); // R4
    end

    for (genvar i = 0; i < 4; i++) begin : g_bp_age
        logic [1:0]       lv_q;
        logic [AGE_W-1:0] age_q;
        always_ff @(posedge clk) begin
            lv_q <= bp_level[2*i +: 2];
            if (rst)                               age_q <= AGE_CAP;
            else if (bp_level[2*i +: 2] != lv_q)   age_q <= AGE_W'(1);
            else if (age_q < AGE_CAP)              age_q <= age_q + AGE_W'(1);
        end
        AST_BP_BOOST: assert property (@(posedge clk) disable iff (rst)
            bp_boost[i] == ((bp_level[2*i +: 2] != lv_q) || (age_q < AGE_CAP))); // R7
    end

    for (genvar f = 0; f < NUM_FP; f++) begin : g_fp_age
        logic [1:0]       lv_q;
        logic [AGE_W-1:0] age_q;
        always_ff @(posedge clk) begin
            lv_q <= fp_level[2*f +: 2];
            if (rst)                               age_q <= AGE_CAP;
            else if (fp_level[2*f +: 2] != lv_q)   age_q <= AGE_W'(1);
            else if (age_q < AGE_CAP)              age_q <= age_q + AGE_W'(1);
        end
        AST_FP_BOOST: assert property (@(posedge clk) disable iff (rst)
            fp_boost[f] == ((fp_level[2*f +: 2] != lv_q) || (age_q < AGE_CAP))); // R7
    end

endmodule

bind lcdmux_drive lcdmux_drive_chk #(
    .NUM_FP    (NUM_FP),
    .SLOT_DIV  (SLOT_DIV),
    .BOOST_CYC (BOOST_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bp_level (bp_level),
    .bp_boost (bp_boost),
    .fp_level (fp_level),
    .fp_boost (fp_boost)
);

// File: tb/sim_lcdmux_drive.sv
module sim_lcdmux_drive;

    localparam int CLK_PERIOD = 10;
    localparam int NFP   = 4;
    localparam int SD    = 3;
    localparam int HOLD  = 4;
    localparam int NSEG  = 4 * NFP;
    localparam int FR    = 4 * SD;
    localparam int PAIRS = 24;
    localparam int RUN   = PAIRS * 2 * FR;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NSEG-1:0]   seg_image;
    logic [7:0]        bp_level;
    logic [3:0]        bp_boost;
    logic [2*NFP-1:0]  fp_level;
    logic [NFP-1:0]    fp_boost;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdmux_drive #(.NUM_FP(NFP), .SLOT_DIV(SD), .BOOST_CYC(HOLD)) u0 (
        .clk       (clk),
        .rst       (rst),
        .seg_image (seg_image),
        .bp_level  (bp_level),
        .bp_boost  (bp_boost),
        .fp_level  (fp_level),
        .fp_boost  (fp_boost)
    );

    function automatic logic [NSEG-1:0] pat(input int k);
        logic [31:0] h;
        if (k == 0)       return '0;
        else if (k == 1)  return '1;
        else if (k == 2)  return NSEG'(32'hAAAA_AAAA);
        else if (k == 3)  return NSEG'(32'h5555_5555);
        else if (k < 4 + NSEG) return NSEG'(1) << (k - 4);
        h = 32'(k) * 32'h9E37_79B9;
        return NSEG'(h >> 7);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NSEG-1:0]  img_m;
        logic [7:0]       exp_bp;
        logic [2*NFP-1:0] exp_fp;
        logic [3:0]       exp_bb;
        logic [NFP-1:0]   exp_fb;
        int prev_bp [4];
        int rem_bp  [4];
        int prev_fp [NFP];
        int rem_fp  [NFP];
        int dc      [NSEG];
        int t;

        seg_image = pat(0);
        img_m     = pat(0);
        rst       = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t   = 0;
        for (int i = 0; i < NSEG; i++) dc[i] = 0;

        // R1: reset state on the first cycle after reset
        check(bp_level == 8'h57, "R1", "bp_level after reset", 64'(bp_level), 64'h57);
        check(bp_boost == '0 && fp_boost == '0, "R1", "boost after reset",
              64'({bp_boost, fp_boost}), 64'h0);

        while (t < RUN) begin
            int  slot;
            bit  neg;
            slot = (t / SD) % 4;
            neg  = ((t / FR) % 2) == 1;

            // R2 R3 R5: backplane codes
            for (int b = 0; b < 4; b++) begin
                int eb;
                if (b == slot) eb = neg ? 0 : 3;
                else           eb = neg ? 2 : 1;
                exp_bp[2*b +: 2] = 2'(eb);
            end
            // R4 R6: frontplane codes from the frame image
            for (int f = 0; f < NFP; f++) begin
                int  ef;
                bit  lit;
                lit = img_m[4*f + slot];
                if (neg) ef = lit ? 3 : 1;
                else     ef = lit ? 0 : 2;
                exp_fp[2*f +: 2] = 2'(ef);
            end
            // R7: boost window model
            for (int b = 0; b < 4; b++) begin
                int  lv;
                bit  ch;
                lv = int'(exp_bp[2*b +: 2]);
                if (t == 0) begin prev_bp[b] = lv; rem_bp[b] = 0; end
                ch = (lv != prev_bp[b]);
                exp_bb[b] = ch || (rem_bp[b] > 0);
                if (ch) rem_bp[b] = HOLD - 1;
                else if (rem_bp[b] > 0) rem_bp[b]--;
                prev_bp[b] = lv;
            end
            for (int f = 0; f < NFP; f++) begin
                int  lv;
                bit  ch;
                lv = int'(exp_fp[2*f +: 2]);
                if (t == 0) begin prev_fp[f] = lv; rem_fp[f] = 0; end
                ch = (lv != prev_fp[f]);
                exp_fb[f] = ch || (rem_fp[f] > 0);
                if (ch) rem_fp[f] = HOLD - 1;
                else if (rem_fp[f] > 0) rem_fp[f]--;
                prev_fp[f] = lv;
            end

            check(bp_level == exp_bp, "R2/R3/R5", "bp_level", 64'(bp_level), 64'(exp_bp));
            check(fp_level == exp_fp, "R4/R6", "fp_level", 64'(fp_level), 64'(exp_fp));
            check(bp_boost == exp_bb, "R7", "bp_boost", 64'(bp_boost), 64'(exp_bb));
            check(fp_boost == exp_fb, "R7", "fp_boost", 64'(fp_boost), 64'(exp_fb));

            // R8: DC sum per segment over each frame pair
            for (int f = 0; f < NFP; f++)
                for (int b = 0; b < 4; b++)
                    dc[4*f + b] += int'(bp_level[2*b +: 2]) - int'(fp_level[2*f +: 2]);
            if (((t + 1) % (2 * FR)) == 0) begin
                int worst;
                worst = 0;
                for (int i = 0; i < NSEG; i++) begin
                    if (dc[i] != 0) worst = dc[i];
                    dc[i] = 0;
                end
                check(worst == 0, "R8", "net DC over frame pair", 64'(worst), 64'h0);
            end

            // R6: brief image flips inside an even frame, new pattern mid odd frame
            if ((t % (2 * FR)) == 5 || (t % (2 * FR)) == 8) seg_image = ~seg_image;
            if ((t % (2 * FR)) == FR + 5) seg_image = pat(t / (2 * FR) + 1);

            @(negedge clk);
            t++;
            if ((t % FR) == 0) img_m = seg_image;
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule